// File: doc/BRIEF.md
# Syncpoint Counter Bank with Threshold Events

The block keeps a bank of free-running 32-bit syncpoint counters that producers advance and consumers wait on. Every counter owns a short list of armed thresholds. When an increment carries a counter to or past an armed threshold, the block sends out an event naming the syncpoint and the threshold, and then disarms that entry. A consumer can also sample a counter, or hold a wait request until the counter catches up with a target. A global shutdown input releases every wait at once.

Commands arrive on one valid/ready stream. `cmd_op` selects the operation: 0 increment, 1 arm threshold, 2 disarm threshold, 3 load fence value, 4 fence acquire. Other codes are accepted and have no effect. The block drops `cmd_ready` while threshold events are still waiting to leave, and while a fence acquire is not yet satisfied. Events leave on a second valid/ready stream. A payload that is offered stays unchanged until `irq_ready` takes it, so the consumer may stall the stream for as long as it needs. The wait port is a request with a combinational grant. Read, the overflow flag and the disarm result are plain signals.

Top module: `sp_syncpt_bank`

## Requirements
- R1: An accepted op 0 (increment) with `cmd_id` below NUM_SP adds one, modulo 2^32, to that counter, and `rd_count` shows the new value from the next cycle. An increment with an id of NUM_SP or more changes nothing.
- R2: After an op 0 increment, every armed threshold of that syncpoint that is less than or equal (unsigned) to the new count produces exactly one event (`irq_id`, `irq_value`) and is then disarmed. A threshold armed at or below the current count waits for the next increment.
- R3: The events from one increment leave one per handshake, lowest slot index first. While `irq_ready` is low, `irq_valid` stays high and `irq_id` and `irq_value` do not change.
- R4: From the cycle after an increment that produces events until the last of those events is taken, `cmd_ready` is low for every op.
- R5: Op 1 (arm) puts `cmd_value` into the lowest free slot of syncpoint `cmd_id`. Arming a value that is already armed on that syncpoint has no effect.
- R6: Op 1 with a new value into a syncpoint whose DEPTH slots are all in use is dropped, and it sets the sticky `ovf` output. Only reset clears `ovf`.
- R7: Op 2 (disarm) removes the entry equal to `cmd_value`. In the cycle after acceptance, `cx_done` pulses high, and `cx_hit` is 1 when an entry was removed and 0 when none matched.
- R8: With `wait_valid` high and a valid `wait_id`, `wait_ready` is high exactly when the counter is greater than or equal to `wait_value` (unsigned).
- R9: While `shutdown` is high, `wait_ready` is high for any pending wait, and an op 4 fence acquire is accepted at once.
- R10: A wait whose `wait_id` is all ones, or any other value of NUM_SP or more, is granted at once with `wait_err` high. `wait_err` is low for a valid id.
- R11: Op 3 stores `cmd_value` as the fence value. Op 4 (fence acquire) on syncpoint `cmd_id` is held with `cmd_ready` low until that counter is greater than or equal to the fence value.
- R12: `rd_count` returns the counter selected by `rd_id`, and returns 0 for an id of NUM_SP or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_id | input | ID_W | Syncpoint id |
| cmd_value | input | CNT_W | Threshold or fence value |
| irq_valid | output | 1 | Threshold event offered |
| irq_ready | input | 1 | Event consumer ready |
| irq_id | output | ID_W | Syncpoint of the event |
| irq_value | output | CNT_W | Threshold that fired |
| wait_valid | input | 1 | Wait request |
| wait_id | input | ID_W | Syncpoint waited on |
| wait_value | input | CNT_W | Target count |
| wait_ready | output | 1 | Wait granted |
| wait_err | output | 1 | Wait rejected for a bad id |
| rd_id | input | ID_W | Read select |
| rd_count | output | CNT_W | Selected counter value |
| shutdown | input | 1 | Release all waits |
| cx_done | output | 1 | Disarm result valid |
| cx_hit | output | 1 | Disarm removed an entry |
| ovf | output | 1 | Sticky threshold list overflow |

## Verification
Directed sequences arm thresholds out of value order and then cross all of them with a single increment. This separates emission in slot order from emission in value order, and shows that a fired entry leaves its list. Further directed cases fill a list and then arm a duplicate and a new value, disarm the same value twice, and arm a threshold at the current count, which tells suppression, overflow, hit/miss and the next-increment rule apart. A seeded random mix of arms, disarms, increments and out-of-range ids runs while the event consumer back-pressures at random, all checked against a bench model of counters and slots. Fence acquire and waits are tried both below and at their targets, and again under shutdown.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_INCR   = 3'd0,
    OP_ARM    = 3'd1,
    OP_DISARM = 3'd2,
    OP_FLOAD  = 3'd3,
    OP_FACQ   = 3'd4
  } sp_op_e;
endpackage

// File: rtl/sp_counter_bank.sv
module sp_counter_bank #(
  parameter int NUM_SP = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(NUM_SP)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inc,
  input  logic [IDX_W-1:0]               inc_idx,
  output logic [NUM_SP-1:0][CNT_W-1:0]   cnt
);
  for (genvar g = 0; g < NUM_SP; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (inc && inc_idx == IDX_W'(g))
        cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sp_thresh_list.sv
module sp_thresh_list #(
  parameter int CNT_W  = 32,
  parameter int DEPTH  = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic                          disarm,
  input  logic [CNT_W-1:0]              val,
  input  logic [CNT_W-1:0]              cmp,
  input  logic                          clr,
  input  logic [SLOT_W-1:0]             clr_slot,
  output logic [DEPTH-1:0]              fire_mask,
  output logic                          hit,
  output logic                          drop,
  output logic [DEPTH-1:0][CNT_W-1:0]   slots
);
  logic [DEPTH-1:0] vld, match;
  logic [SLOT_W-1:0] free_idx;
  logic has_free;

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!vld[k]) begin
        free_idx = SLOT_W'(k);
        has_free = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign match[k]     = vld[k] && (slots[k] == val);
    assign fire_mask[k] = vld[k] && (slots[k] <= cmp);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[k]   <= 1'b0;
        slots[k] <= '0;
      end else begin
        if (clr && clr_slot == SLOT_W'(k)) vld[k] <= 1'b0;
        if (disarm && match[k]) vld[k] <= 1'b0;
        if (arm && !hit && has_free && free_idx == SLOT_W'(k)) begin
          vld[k]   <= 1'b1;
          slots[k] <= val;
        end
      end
    end
  end

  assign hit  = |match;
  assign drop = arm && !hit && !has_free;
endmodule

// File: rtl/sp_irq_drain.sv
module sp_irq_drain #(
  parameter int NUM_SP = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W  = $clog2(NUM_SP),
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DEPTH-1:0]   load_mask,
  input  logic [IDX_W-1:0]   load_idx,
  input  logic               irq_ready,
  output logic               busy,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [SLOT_W-1:0]  cur_slot,
  output logic               take
);
  logic [DEPTH-1:0] pend;

  always_comb begin
    cur_slot = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (pend[k]) cur_slot = SLOT_W'(k);
  end

  assign busy = |pend;
  assign take = busy && irq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      cur_idx <= '0;
    end else if (load) begin
      pend    <= load_mask;
      cur_idx <= load_idx;
    end else if (take) begin
      pend[cur_slot] <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_syncpt_bank.sv
module sp_syncpt_bank
  import sp_pkg::*;
#(
  parameter int NUM_SP = 8,
  parameter int CNT_W  = 32,
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ID_W-1:0]    cmd_id,
  input  logic [CNT_W-1:0]   cmd_value,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [ID_W-1:0]    irq_id,
  output logic [CNT_W-1:0]   irq_value,
  input  logic               wait_valid,
  input  logic [ID_W-1:0]    wait_id,
  input  logic [CNT_W-1:0]   wait_value,
  output logic               wait_ready,
  output logic               wait_err,
  input  logic [ID_W-1:0]    rd_id,
  output logic [CNT_W-1:0]   rd_count,
  input  logic               shutdown,
  output logic               cx_done,
  output logic               cx_hit,
  output logic               ovf
);
  localparam int IDX_W  = $clog2(NUM_SP);
  localparam int SLOT_W = $clog2(DEPTH);

  initial begin
    if (NUM_SP >= (1 << ID_W)) $error("ID_W too narrow for NUM_SP");
  end

  sp_op_e op;
  assign op = sp_op_e'(cmd_op);

  logic cmd_ok, wait_ok, rd_ok;
  logic [IDX_W-1:0] cmd_idx, wait_idx, rd_idx;
  assign cmd_ok   = cmd_id  < ID_W'(NUM_SP);
  assign wait_ok  = wait_id < ID_W'(NUM_SP);
  assign rd_ok    = rd_id   < ID_W'(NUM_SP);
  assign cmd_idx  = cmd_id[IDX_W-1:0];
  assign wait_idx = wait_id[IDX_W-1:0];
  assign rd_idx   = rd_id[IDX_W-1:0];

  logic [NUM_SP-1:0][CNT_W-1:0]             cnt_bank;
  logic [NUM_SP-1:0][DEPTH-1:0]             mask_all;
  logic [NUM_SP-1:0]                        hit_all, drop_all;
  logic [NUM_SP-1:0][DEPTH-1:0][CNT_W-1:0]  slots_all;
  logic [CNT_W-1:0] fence_val;

  logic drn_busy, drn_take;
  logic [IDX_W-1:0]  drn_idx;
  logic [SLOT_W-1:0] drn_slot;

  logic fence_ok, cmd_fire, do_inc, drn_load;
  assign fence_ok  = shutdown || !cmd_ok || (cnt_bank[cmd_idx] >= fence_val);
  assign cmd_ready = !drn_busy && ((op != OP_FACQ) || fence_ok);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign do_inc    = cmd_fire && (op == OP_INCR) && cmd_ok;
  assign drn_load  = do_inc && (|mask_all[cmd_idx]);

  sp_counter_bank #(.NUM_SP(NUM_SP), .CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .inc(do_inc), .inc_idx(cmd_idx), .cnt(cnt_bank)
  );

  for (genvar g = 0; g < NUM_SP; g++) begin : g_list
    logic sel;
    assign sel = cmd_fire && cmd_ok && (cmd_idx == IDX_W'(g));
    sp_thresh_list #(.CNT_W(CNT_W), .DEPTH(DEPTH)) list_i (
      .clk(clk), .rst_n(rst_n),
      .arm(sel && op == OP_ARM),
      .disarm(sel && op == OP_DISARM),
      .val(cmd_value),
      .cmp(cnt_bank[g] + CNT_W'(1)),
      .clr(drn_take && drn_idx == IDX_W'(g)),
      .clr_slot(drn_slot),
      .fire_mask(mask_all[g]),
      .hit(hit_all[g]),
      .drop(drop_all[g]),
      .slots(slots_all[g])
    );
  end

  sp_irq_drain #(.NUM_SP(NUM_SP), .DEPTH(DEPTH)) drn_i (
    .clk(clk), .rst_n(rst_n),
    .load(drn_load), .load_mask(mask_all[cmd_idx]), .load_idx(cmd_idx),
    .irq_ready(irq_ready),
    .busy(drn_busy), .cur_idx(drn_idx), .cur_slot(drn_slot), .take(drn_take)
  );

  assign irq_valid = drn_busy;
  assign irq_id    = ID_W'(drn_idx);
  assign irq_value = slots_all[drn_idx][drn_slot];

  assign wait_err   = wait_valid && !wait_ok;
  assign wait_ready = wait_valid &&
                      (!wait_ok || shutdown || (cnt_bank[wait_idx] >= wait_value));
  assign rd_count   = rd_ok ? cnt_bank[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx_done   <= 1'b0;
      cx_hit    <= 1'b0;
      ovf       <= 1'b0;
      fence_val <= '0;
    end else begin
      cx_done <= cmd_fire && (op == OP_DISARM);
      cx_hit  <= cmd_fire && (op == OP_DISARM) && cmd_ok && hit_all[cmd_idx];
      if (|drop_all) ovf <= 1'b1;
      if (cmd_fire && op == OP_FLOAD) fence_val <= cmd_value;
    end
  end
endmodule

// File: rtl/sp_syncpt_bank_chk.sv
module sp_syncpt_bank_chk #(
  parameter int NUM_SP = 8,
  parameter int CNT_W  = 32,
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic                         cmd_ready,
  input logic [2:0]                   cmd_op,
  input logic [ID_W-1:0]              cmd_id,
  input logic                         irq_valid,
  input logic                         irq_ready,
  input logic [ID_W-1:0]              irq_id,
  input logic [CNT_W-1:0]             irq_value,
  input logic                         wait_valid,
  input logic [ID_W-1:0]              wait_id,
  input logic                         wait_ready,
  input logic                         wait_err,
  input logic                         shutdown,
  input logic                         cx_done,
  input logic                         cx_hit,
  input logic [NUM_SP-1:0][CNT_W-1:0] cnt_bank
);
  localparam int IDX_W = $clog2(NUM_SP);

  logic inc_q;
  logic [IDX_W-1:0] inc_idx_q;
  logic [CNT_W-1:0] inc_exp_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q     <= 1'b0;
      inc_idx_q <= '0;
      inc_exp_q <= '0;
    end else begin
      inc_q     <= cmd_valid && cmd_ready && cmd_op == 3'd0 && cmd_id < ID_W'(NUM_SP);
      inc_idx_q <= cmd_id[IDX_W-1:0];
      inc_exp_q <= cnt_bank[cmd_id[IDX_W-1:0]] + CNT_W'(1);
    end
  end

  a_r1_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_q |-> cnt_bank[inc_idx_q] == inc_exp_q);

  a_r2_fired_reached: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_value <= cnt_bank[irq_id[IDX_W-1:0]]);

  a_r3_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_id) && $stable(irq_value));

  a_r4_block_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !cmd_ready);

  a_r7_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    cx_hit |-> cx_done);

  a_r9_shutdown_grant: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid && shutdown |-> wait_ready);

  a_r10_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    wait_valid && (wait_id == '1) |-> wait_ready && wait_err);
endmodule

bind sp_syncpt_bank sp_syncpt_bank_chk #(
  .NUM_SP(NUM_SP), .CNT_W(CNT_W), .DEPTH(DEPTH), .ID_W(ID_W)
) chk_i (.*);

// File: tb/sp_syncpt_bank_tb_top.sv
`timescale 1ns/1ps
module sp_syncpt_bank_tb_top;
  localparam int NSP = 8;
  localparam int DP  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_id = '0;
  logic [31:0] cmd_value = '0;
  logic irq_valid, irq_ready = 1'b0;
  logic [3:0] irq_id;
  logic [31:0] irq_value;
  logic wait_valid = 1'b0;
  logic [3:0] wait_id = '0;
  logic [31:0] wait_value = '0;
  logic wait_ready, wait_err;
  logic [3:0] rd_id = '0;
  logic [31:0] rd_count;
  logic shutdown = 1'b0;
  logic cx_done, cx_hit, ovf;

  always #10 clk = ~clk;

  sp_syncpt_bank dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int unsigned m_cnt [NSP];
  bit          m_v   [NSP][DP];
  int unsigned m_t   [NSP][DP];
  bit          m_ovf = 1'b0;
  int unsigned q_id[$], q_val[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pushed_events(input int id);
    int n = 0;
    m_cnt[id]++;
    for (int k = 0; k < DP; k++)
      if (m_v[id][k] && m_t[id][k] <= m_cnt[id]) begin
        q_id.push_back(id); q_val.push_back(m_t[id][k]); m_v[id][k] = 1'b0; n++;
      end
    return n;
  endfunction

  function automatic bit model_arm_disarm(input bit arm, input int id, input int unsigned v);
    bit found = 1'b0;
    for (int k = 0; k < DP; k++)
      if (m_v[id][k] && m_t[id][k] == v) begin
        found = 1'b1;
        if (!arm) m_v[id][k] = 1'b0;
      end
    if (arm && !found) begin
      bit placed = 1'b0;
      for (int k = 0; k < DP; k++)
        if (!placed && !m_v[id][k]) begin m_v[id][k] = 1'b1; m_t[id][k] = v; placed = 1'b1; end
      if (!placed) m_ovf = 1'b1;
    end
    return found;
  endfunction

  task automatic send(input logic [2:0] op, input logic [3:0] id, input logic [31:0] v);
    int nev = 0;
    bit exp_hit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_value = v; #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    if (id < NSP) begin
      if (op == 3'd0) nev = pushed_events(id);
      if (op == 3'd1) void'(model_arm_disarm(1'b1, id, v));
      if (op == 3'd2) exp_hit = model_arm_disarm(1'b0, id, v);
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (op == 3'd2) begin
      chk("R7 cx_done", cx_done, 1'b1);
      chk("R7 cx_hit", cx_hit, exp_hit);
    end
    if (op == 3'd0 && nev > 0) chk("R4 cmd_ready held", cmd_ready, 1'b0);
    if (op == 3'd1) chk("R6 ovf", ovf, m_ovf);
  endtask

  task automatic probe(input logic [3:0] rid, input logic [3:0] wid, input logic [31:0] wv);
    @(negedge clk);
    rd_id = rid; wait_valid = 1'b1; wait_id = wid; wait_value = wv; #1;
    chk("R12 rd_count", rd_count, rid < NSP ? m_cnt[rid] : 32'd0);
    if (wid < NSP) begin
      chk("R8 wait_ready", wait_ready, shutdown || m_cnt[wid] >= wv);
      chk("R10 wait_err valid id", wait_err, 1'b0);
    end else begin
      chk("R10 wait_ready bad id", wait_ready, 1'b1);
      chk("R10 wait_err bad id", wait_err, 1'b1);
    end
    wait_valid = 1'b0;
  endtask

  task automatic drain_wait();
    int guard = 0;
    while ((q_id.size() != 0 || irq_valid) && guard < 200) begin @(negedge clk); #2; guard++; end
  endtask

  // event consumer with random back-pressure (R2, R3)
  initial begin
    forever begin
      @(negedge clk);
      irq_ready = ($urandom % 3) != 0;
      #1;
      if (irq_valid && irq_ready) begin
        if (q_id.size() == 0) chk("R2 unexpected event", {28'd0, irq_id}, 32'hFFFF_FFFF);
        else begin
          chk("R3 event id order", {28'd0, irq_id}, q_id.pop_front());
          chk("R3 event value order", irq_value, q_val.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NSP; i++) begin
      m_cnt[i] = 0;
      for (int k = 0; k < DP; k++) begin m_v[i][k] = 1'b0; m_t[i][k] = 0; end
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset count", rd_count, 32'd0);
    chk("R4 reset cmd_ready", cmd_ready, 1'b1);
    chk("R3 reset irq_valid", irq_valid, 1'b0);
    chk("R6 reset ovf", ovf, 1'b0);

    // R5 duplicate, R2 firing as count crosses each value
    send(3'd1, 4'd1, 32'd3); send(3'd1, 4'd1, 32'd1); send(3'd1, 4'd1, 32'd5);
    send(3'd1, 4'd1, 32'd3);
    for (int i = 0; i < 5; i++) begin send(3'd0, 4'd1, 32'd0); drain_wait(); end
    probe(4'd1, 4'd1, 32'd5);
    send(3'd0, 4'd1, 32'd0); drain_wait();
    chk("R2 no refire", q_id.size(), 32'd0);

    // R6 overflow, duplicate into full list ignored
    for (int i = 0; i < DP; i++) send(3'd1, 4'd4, 32'd10 + i);
    send(3'd1, 4'd4, 32'd10);
    chk("R5 duplicate on full list", ovf, 1'b0);
    send(3'd1, 4'd4, 32'd20);
    chk("R6 overflow set", ovf, 1'b1);
    // R7 disarm hit then miss
    send(3'd2, 4'd4, 32'd11);
    send(3'd2, 4'd4, 32'd11);

    // R2 threshold at current count waits for next increment
    send(3'd1, 4'd5, 32'd0);
    probe(4'd5, 4'd5, 32'd0);
    chk("R2 no event before increment", irq_valid, 1'b0);
    send(3'd0, 4'd5, 32'd0); drain_wait();

    // R3 multi-fire in slot order, values out of order
    for (int i = 0; i < 5; i++) send(3'd0, 4'd7, 32'd0);
    send(3'd1, 4'd7, 32'd6); send(3'd1, 4'd7, 32'd2); send(3'd1, 4'd7, 32'd4);
    send(3'd0, 4'd7, 32'd0); drain_wait();

    // R1 invalid id ignored, R10/R12 bad ids
    send(3'd0, 4'd9, 32'd0);
    for (int i = 0; i < NSP; i++) probe(4'(i), 4'(i), m_cnt[i]);
    probe(4'd15, 4'd15, 32'd0);
    probe(4'd8, 4'd8, 32'd0);
    probe(4'd2, 4'd2, 32'd1);

    // R11 fence acquire satisfied then blocking
    send(3'd3, 4'd0, 32'd0);
    send(3'd4, 4'd1, 32'd0);
    send(3'd3, 4'd0, m_cnt[3] + 32'd2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_id = 4'd3; #1;
    repeat (3) begin chk("R11 acquire held", cmd_ready, 1'b0); @(negedge clk); #1; end
    shutdown = 1'b1; #1;
    chk("R9 acquire released", cmd_ready, 1'b1);
    @(posedge clk); #1; cmd_valid = 1'b0;
    probe(4'd3, 4'd3, 32'hFFFF_FFF0);
    shutdown = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom % 10;
      logic [3:0] id = ($urandom % 12 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % NSP);
      logic [31:0] v = (id < NSP ? m_cnt[id] : 0) + ($urandom % 6);
      if (r < 4) send(3'd0, id, 32'd0);
      else if (r < 7) send(3'd1, id, v);
      else if (r < 9) send(3'd2, id, v);
      else send(3'd5, id, v);
      drain_wait();
      probe(4'($urandom % 9), id, v);
    end
    drain_wait();
    chk("R2 all events seen", q_id.size(), 32'd0);
    chk("R6 final ovf", ovf, m_ovf);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule